// File: doc/BRIEF.md
# Automatic CTS Transmit Gate

This block decides whether a UART transmit engine may begin its next frame, based on the clear-to-send level from the remote receiver. The remote pulls its active-low CTS line high when its receive buffer cannot take more data. The gate brings that line into the local clock domain through a synchronizer. It then takes a fresh start decision only when the transmitter reports that it is idle, or that the stop bit of the current frame has just finished. A frame that has already started is therefore never cut short. When CTS returns low, the next boundary sample lets transmission resume.

If the synchronized CTS line rises while gating and its interrupt are both enabled, a sticky status flag is set. That flag stays set until software pulses a read-clear strobe, and the interrupt line is the status flag qualified by the interrupt enable. When gating is switched off, the permit output is forced high and the CTS level has no effect on it.

Top module: `cts_tx_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `cts_stat` and `cts_irq` are 0, and the internal start decision is "blocked", so `tx_permit` is 0 whenever `gate_en` is 1.
- R2: While `gate_en` is 0, `tx_permit` is 1 whatever the level of `cts_n_pin`.
- R3: `cts_n_pin` passes through a two-flop synchronizer. With `tx_idle` held at 1, a pin change first shows on `tx_permit` after the third rising clock edge that follows it, and not earlier.
- R4: When `cts_n_pin` goes to 1 while a frame is in progress (`tx_idle` = 0), `tx_permit` stays at 1 until the clock edge at which `tx_stop_end` is 1. It is 0 after that edge.
- R5: When `cts_n_pin` returns to 0, `tx_permit` returns to 1 at the first boundary sample (`tx_idle` or `tx_stop_end` at 1) that sees the synchronized low level.
- R6: A 0-to-1 change of the synchronized CTS level sets `cts_stat` at the next edge, but only if `gate_en` and `cts_irq_en` are both 1. Without both enables, the flag is not set.
- R7: `cts_stat` holds its value until an edge with `stat_clr` = 1 clears it. If a set event and `stat_clr` fall in the same cycle, the set wins.
- R8: `cts_irq` is 1 exactly when `cts_stat` is 1 and `cts_irq_en` is 1.
- R9: The start decision changes only at edges where `tx_idle` or `tx_stop_end` is 1. A CTS pulse that starts and ends inside a frame leaves `tx_permit` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cts_n_pin | input | 1 | Remote clear-to-send, active low, asynchronous |
| gate_en | input | 1 | 1 enables automatic CTS gating |
| cts_irq_en | input | 1 | 1 enables the CTS status flag and interrupt |
| tx_idle | input | 1 | Transmitter has no frame in progress |
| tx_stop_end | input | 1 | One-cycle strobe: stop bit of current frame finished |
| stat_clr | input | 1 | Read-clear strobe for the status flag |
| tx_permit | output | 1 | 1 allows the transmitter to start a new frame |
| cts_stat | output | 1 | Sticky flag: CTS deassert seen |
| cts_irq | output | 1 | Interrupt request |

## Verification
The risky overlap is a CTS set event and a read-clear strobe in the same cycle. The bench holds `stat_clr` high across the whole window in which the synchronized rising edge arrives. It expects the flag to be set at that edge and cleared one edge later. A second overlap arises when a stop-bit strobe coincides with a synchronized CTS change: the behavioural model compares the permit decision on every clock against the level that CTS had at that boundary. Random traffic on all inputs drives both overlaps repeatedly.

// File: rtl/cts_gate_pkg.sv
// Package: shared types for the CTS transmit gate.
// Assumes: the transmitter frame-boundary indications are single-bit, same clock.
package cts_gate_pkg;

    // Frame-boundary indications from the transmit engine
    typedef struct packed {
        logic idle;      // no frame in progress
        logic stop_end;  // stop bit finished this cycle
    } tx_bound_t;

    // True when a new start decision may be taken
    function automatic logic at_boundary(input tx_bound_t b);
        return b.idle | b.stop_end;
    endfunction

endpackage

// File: rtl/cts_gate_sync.sv
// Module: cts_gate_sync
// Brings the asynchronous active-low CTS pin into the clock domain through a
// flop chain, and flags the cycle in which the synchronized level rises.
// Assumes: STAGES >= 2; reset value is "not clear" (1) so no false edge.
module cts_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         prev_q;

    // Shift the pin level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[TOP-1:0], pin_i};
    end

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[TOP];
    end

    assign sync_o = chain_q[TOP];
    assign rise_o = chain_q[TOP] & ~prev_q;

    generate
        if (STAGES == 2) begin : g_chk2
            // R3
            sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2)) |-> (sync_o == $past(pin_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/cts_gate_permit.sv
// Module: cts_gate_permit
// Holds the start decision for the transmitter. It re-samples the synchronized
// CTS level only at a frame boundary, so a running frame is never cut short.
// Assumes: stop_end pulses for exactly the cycle the stop bit completes.
module cts_gate_permit
    import cts_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cts_sync_i,
    input  tx_bound_t bound_i,
    input  logic      gate_en_i,
    output logic      permit_o
);
    logic permit_q;
    logic sample;

    assign sample = at_boundary(bound_i);

    // Update the start decision at boundaries only
    always_ff @(posedge clk) begin
        if (!rst_n)      permit_q <= 1'b0;
        else if (sample) permit_q <= ~cts_sync_i;
    end

    // Gating disabled forces the permit high
    always_comb begin
        permit_o = gate_en_i ? permit_q : 1'b1;
    end

    // R9
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (permit_q != $past(permit_q))) |-> $past(sample));

    // R4
    stop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(permit_q) && !$past(sample)) |-> permit_q);

endmodule

// File: rtl/cts_gate_status.sv
// Module: cts_gate_status
// Sticky CTS-deassert flag with read-clear, and the qualified interrupt.
// Assumes: rise_i is a one-cycle pulse from the synchronizer edge detector.
module cts_gate_status (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic gate_en_i,
    input  logic irq_en_i,
    input  logic clr_i,
    output logic stat_o,
    output logic irq_o
);
    logic stat_q;
    logic set_evt;

    assign set_evt = rise_i & gate_en_i & irq_en_i;

    // Set on a qualified CTS rise; clear on read strobe; set wins
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= 1'b0;
        else if (set_evt) stat_q <= 1'b1;
        else if (clr_i)   stat_q <= 1'b0;
    end

    // Interrupt is the flag qualified by its enable
    always_comb begin
        stat_o = stat_q;
        irq_o  = stat_q & irq_en_i;
    end

    // R6
    set_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rise_i && gate_en_i && irq_en_i)) |-> stat_q);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stat_q) && !$past(clr_i)) |-> stat_q);

endmodule

// File: rtl/cts_tx_gate.sv
// Module: cts_tx_gate (top)
// Automatic CTS transmit gate: synchronizes the remote CTS pin, holds the
// transmit start decision between frame boundaries, and latches a status
// flag and interrupt when CTS deasserts.
// Assumes: tx_idle and tx_stop_end come from the transmit engine on clk.
module cts_tx_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_pin,
    input  logic gate_en,
    input  logic cts_irq_en,
    input  logic tx_idle,
    input  logic tx_stop_end,
    input  logic stat_clr,
    output logic tx_permit,
    output logic cts_stat,
    output logic cts_irq
);
    import cts_gate_pkg::*;

    logic      cts_sync;
    logic      cts_rise;
    tx_bound_t bound;

    assign bound = '{idle: tx_idle, stop_end: tx_stop_end};

    cts_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cts_n_pin),
        .sync_o (cts_sync),
        .rise_o (cts_rise)
    );

    cts_gate_permit u_permit (
        .clk        (clk),
        .rst_n      (rst_n),
        .cts_sync_i (cts_sync),
        .bound_i    (bound),
        .gate_en_i  (gate_en),
        .permit_o   (tx_permit)
    );

    cts_gate_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (cts_rise),
        .gate_en_i (gate_en),
        .irq_en_i  (cts_irq_en),
        .clr_i     (stat_clr),
        .stat_o    (cts_stat),
        .irq_o     (cts_irq)
    );

endmodule

// File: tb/test_cts_tx_gate.sv
module test_cts_tx_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_n_pin = 1'b0;
    logic gate_en = 1'b1;
    logic cts_irq_en = 1'b1;
    logic tx_idle = 1'b1;
    logic tx_stop_end = 1'b0;
    logic stat_clr = 1'b0;
    logic tx_permit, cts_stat, cts_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cts_tx_gate i_cts_tx_gate (
        .clk(clk), .rst_n(rst_n), .cts_n_pin(cts_n_pin), .gate_en(gate_en),
        .cts_irq_en(cts_irq_en), .tx_idle(tx_idle), .tx_stop_end(tx_stop_end),
        .stat_clr(stat_clr), .tx_permit(tx_permit), .cts_stat(cts_stat),
        .cts_irq(cts_irq)
    );

    // Behavioural reference: pending pin samples in a queue, plain state bits
    bit pend[$];
    bit m_sync = 1, m_prev = 1, m_perm = 0, m_stat = 0;

    always @(posedge clk) begin
        bit rise;
        started = 1;
        if (!rst_n) begin
            pend = {1'b1};
            m_sync = 1; m_prev = 1; m_perm = 0; m_stat = 0;
        end else begin
            rise = m_sync && !m_prev;
            if (tx_idle || tx_stop_end) m_perm = !m_sync;
            if (rise && gate_en && cts_irq_en) m_stat = 1;
            else if (stat_clr) m_stat = 0;
            m_prev = m_sync;
            pend.push_back(cts_n_pin);
            m_sync = pend.pop_front();
        end
    end

    task automatic chk(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R4 permit", tx_permit, gate_en ? m_perm : 1'b1);
            chk("R7 stat", cts_stat, m_stat);
            chk("R8 irq", cts_irq, m_stat & cts_irq_en);
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 permit", tx_permit, 1'b0);
        chk("R1 stat", cts_stat, 1'b0);
        chk("R1 irq", cts_irq, 1'b0);
        rst_n = 1;
        tick(2);
        chk("R3 not yet", tx_permit, 1'b0);
        tick(1);
        chk("R3 third edge", tx_permit, 1'b1);

        // R9: short CTS pulse inside a frame does not drop permit
        tx_idle = 0;
        cts_n_pin = 1; tick(1); cts_n_pin = 0;
        tick(5);
        chk("R9 pulse ignored", tx_permit, 1'b1);
        chk("R6 set by pulse", cts_stat, 1'b1);
        stat_clr = 1; tick(1); stat_clr = 0;
        chk("R7 cleared", cts_stat, 1'b0);

        // R4: deassert mid-frame waits for the stop bit
        cts_n_pin = 1;
        tick(5);
        chk("R4 held mid-frame", tx_permit, 1'b1);
        tx_stop_end = 1; tick(1); tx_stop_end = 0;
        chk("R4 drop after stop", tx_permit, 1'b0);
        tx_idle = 1;
        chk("R8 irq on", cts_irq, 1'b1);
        cts_irq_en = 0; #1;
        chk("R8 irq masked", cts_irq, 1'b0);
        chk("R7 held", cts_stat, 1'b1);
        cts_irq_en = 1;

        // R5: resume when CTS returns low
        cts_n_pin = 0;
        tick(2);
        chk("R5 not yet", tx_permit, 1'b0);
        tick(1);
        chk("R5 resumed", tx_permit, 1'b1);

        // R6: no flag without the interrupt enable
        stat_clr = 1; tick(1); stat_clr = 0;
        cts_irq_en = 0;
        cts_n_pin = 1;
        tick(4);
        chk("R6 no set", cts_stat, 1'b0);
        chk("R4 idle blocked", tx_permit, 1'b0);
        cts_irq_en = 1;

        // R2: gating disabled forces permit high; no flag either
        gate_en = 0; #1;
        chk("R2 forced", tx_permit, 1'b1);
        cts_n_pin = 0; tick(4);
        cts_n_pin = 1; tick(4);
        chk("R2 still forced", tx_permit, 1'b1);
        chk("R6 no set ungated", cts_stat, 1'b0);

        // R7: set and clear in the same cycle, set wins
        gate_en = 1;
        cts_n_pin = 0; tick(4);
        stat_clr = 1; cts_n_pin = 1;
        tick(3);
        chk("R7 set wins", cts_stat, 1'b1);
        tick(1);
        chk("R7 clear next", cts_stat, 1'b0);
        stat_clr = 0;

        // Random traffic, compared each cycle by the model
        for (int i = 0; i < 2000; i++) begin
            cts_n_pin   = ($urandom % 4) == 0;
            tx_idle     = ($urandom % 3) == 0;
            tx_stop_end = ($urandom % 5) == 0;
            stat_clr    = ($urandom % 6) == 0;
            gate_en     = ($urandom % 10) != 0;
            cts_irq_en  = ($urandom % 8) != 0;
            tick(1);
        end
        finish_run();
    end
endmodule